// File: doc/BRIEF.md
# Ethernet Transmit Pad and Retry Controller

This block sits in a MAC transmit path, between the buffer that supplies a frame body one byte at a time and the FCS generator. It forwards body bytes unchanged over a valid/ready stream. When the body ends before the frame would reach the minimum length, it adds pad bytes until the frame is long enough. The pad value comes from a programmable 16-bit pattern register, not from zeros. The length that padding aims for is four bytes less than the minimum length, which leaves room for the FCS that follows downstream.

The block also supervises retransmission. Each new frame loads a retry counter from a programmable limit. An external collision pulse restarts the frame from its first byte: the block asks the byte source to rewind and decrements the counter. If a collision arrives when the counter is already at zero, the block gives up on the frame and raises a one-cycle abort interrupt. A frame-done pulse from the MAC ends a frame that has been transmitted successfully. Collision detection, backoff timing and FCS computation are handled elsewhere.

Top module: `txp_pad_retry`

## Requirements
- R1: After reset, and while idle, out_valid_o, out_last_o, src_ready_o, rewind_o and abort_irq_o are all 0. A collision while idle causes neither a rewind nor an abort.
- R2: Body bytes pass to the output in order and unchanged. A byte moves only in a cycle where src_valid_i and out_ready_i are both 1, and such a cycle also asserts src_ready_o.
- R3: Let the pad target be min_len_i minus 4 when min_len_i is greater than 4, and 0 otherwise. A body shorter than the target is followed by pad bytes until the total equals the target. Every pad byte equals pad_pattern_i[7:0].
- R4: A body at least as long as the pad target is sent without pad bytes.
- R5: With min_len_i at 4 or below, no frame is padded.
- R6: A collision during an active frame while retries remain asserts rewind_o in that same cycle. The frame then restarts from its first byte, and any padding is computed again.
- R7: A collision during an active frame with the retry counter at zero asserts abort_irq_o for that cycle, without rewind_o. The block returns to idle.
- R8: The retry counter loads from retry_limit_i when a new frame starts. A frame with limit L allows exactly L rewinds, and the next collision aborts it. A later frame gets the full L again.
- R9: out_last_o is 1 on exactly the final byte of the frame. After that byte the block waits for done_i, which returns it to idle. A done_i before the final byte has no effect.
- R10: start_i during an active frame is ignored and does not reload the retry counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pad_pattern_i | input | 16 | Pad pattern, low byte used |
| min_len_i | input | LEN_W | Minimum frame length in bytes, FCS included |
| retry_limit_i | input | RTY_W | Retries allowed per frame |
| start_i | input | 1 | Begin a new frame (while idle) |
| col_i | input | 1 | Collision pulse |
| done_i | input | 1 | Frame transmitted successfully |
| src_valid_i | input | 1 | Body byte available |
| src_data_i | input | 8 | Body byte |
| src_last_i | input | 1 | Body byte is the last of the body |
| src_ready_o | output | 1 | Body byte accepted |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Output byte ends the frame before FCS |
| out_ready_i | input | 1 | Downstream accepts byte |
| rewind_o | output | 1 | Source must restart from the first body byte |
| abort_irq_o | output | 1 | Retry limit exhausted, frame abandoned |

## Verification
The bench sweeps body lengths from 1 to 20 against several minimum lengths, including one at 4, under both free-flowing and stalled handshakes. Off-by-one errors around the FCS allowance therefore show up, as either one pad byte too many or too few, or a misplaced last flag. Collision runs count rewinds and aborts. They catch a counter that allows L+1 attempts, one that does not reload for the next frame, and one that reloads on a stray mid-frame start. Restarted frames are compared byte for byte, which exposes a length count that is not cleared on rewind: such a design would pad the retried frame short. An early done pulse is applied to show that a design which ends the frame on it truncates the output.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int FCS_BYTES = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_PAD, ST_WAIT} txp_state_e;
endpackage

// File: rtl/txp_len_track.sv
module txp_len_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] min_len_i,
  output logic             reach_o
);
  localparam logic [LEN_W:0] FCS_LEN = (LEN_W+1)'(txp_pkg::FCS_BYTES);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   target, next_cnt;

  always_comb begin
    target   = ({1'b0, min_len_i} > FCS_LEN) ? ({1'b0, min_len_i} - FCS_LEN) : '0;
    next_cnt = {1'b0, cnt_q} + 1'b1;
    reach_o  = next_cnt >= target;  // byte now moving completes the target
  end

  // saturate so very long bodies never wrap into a pad request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txp_retry_ctr.sv
module txp_retry_ctr #(
  parameter int RTY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [RTY_W-1:0] limit_i,
  output logic             zero_o
);
  logic [RTY_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= limit_i;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/txp_pad_retry.sv
module txp_pad_retry #(
  parameter int LEN_W  = 16,
  parameter int RTY_W  = 16,
  parameter bit PAD_HI = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      pad_pattern_i,
  input  logic [LEN_W-1:0] min_len_i,
  input  logic [RTY_W-1:0] retry_limit_i,
  input  logic             start_i,
  input  logic             col_i,
  input  logic             done_i,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_last_i,
  output logic             src_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  input  logic             out_ready_i,
  output logic             rewind_o,
  output logic             abort_irq_o
);
  import txp_pkg::*;

  txp_state_e state_q, state_d;
  logic [7:0] pad_byte;
  logic       reach, rty_zero, col_hit, body_hs, pad_hs, len_clr, rty_load;

  generate
    if (PAD_HI) begin : g_pad_hi
      assign pad_byte = pad_pattern_i[15:8];
    end else begin : g_pad_lo
      assign pad_byte = pad_pattern_i[7:0];
    end
  endgenerate

  txp_len_track #(.LEN_W(LEN_W)) i_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (len_clr),
    .inc_i     (body_hs | pad_hs),
    .min_len_i (min_len_i),
    .reach_o   (reach)
  );

  txp_retry_ctr #(.RTY_W(RTY_W)) i_rty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rty_load),
    .dec_i   (rewind_o),
    .limit_i (retry_limit_i),
    .zero_o  (rty_zero)
  );

  always_comb begin
    col_hit     = (state_q != ST_IDLE) && col_i;
    rewind_o    = col_hit && !rty_zero;
    abort_irq_o = col_hit && rty_zero;
    src_ready_o = (state_q == ST_BODY) && out_ready_i && !col_i;
    out_valid_o = !col_i && (((state_q == ST_BODY) && src_valid_i) || (state_q == ST_PAD));
    out_data_o  = (state_q == ST_PAD) ? pad_byte : src_data_i;
    out_last_o  = out_valid_o && reach &&
                  (((state_q == ST_BODY) && src_last_i) || (state_q == ST_PAD));
    body_hs     = (state_q == ST_BODY) && src_valid_i && out_ready_i && !col_i;
    pad_hs      = (state_q == ST_PAD) && out_ready_i && !col_i;
    rty_load    = (state_q == ST_IDLE) && start_i;
    len_clr     = rty_load || rewind_o;
  end

  always_comb begin
    state_d = state_q;
    if (col_hit) begin
      state_d = rty_zero ? ST_IDLE : ST_BODY;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_BODY;
        ST_BODY: if (body_hs && src_last_i) state_d = reach ? ST_WAIT : ST_PAD;
        ST_PAD:  if (pad_hs && reach) state_d = ST_WAIT;
        ST_WAIT: if (done_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/txp_pad_retry_chk.sv
module txp_pad_retry_chk #(
  parameter int RTY_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                col_i,
  input logic                done_i,
  input logic [RTY_W-1:0]    retry_limit_i,
  input logic [15:0]         pad_pattern_i,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic                out_last_o,
  input logic                src_ready_o,
  input logic                rewind_o,
  input logic                abort_irq_o,
  input txp_pkg::txp_state_e state_q
);
  import txp_pkg::*;

  logic [RTY_W-1:0] cap_q;
  logic [RTY_W:0]   nrw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      nrw_q <= '0;
    end else if (state_q == ST_IDLE && start_i) begin
      cap_q <= retry_limit_i;
      nrw_q <= '0;
    end else if (rewind_o) begin
      nrw_q <= nrw_q + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !out_valid_o && !src_ready_o && !rewind_o && !abort_irq_o);
  a_r7_abort_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_irq_o && rewind_o));
  a_r6_rewind_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_o |-> col_i && !out_valid_o);
  a_r6_restart_body: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_o |=> state_q == ST_BODY);
  a_r7_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_irq_o |=> state_q == ST_IDLE && !out_valid_o);
  a_r3_pad_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD && !col_i) |-> out_valid_o && !src_ready_o);
  a_r9_wait_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !out_valid_o && !out_last_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && done_i && !col_i) |=> state_q == ST_IDLE);
  a_r9_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_last_o && out_ready_i) |=> state_q == ST_WAIT);
  a_r8_rewind_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrw_q <= {1'b0, cap_q});
endmodule

bind txp_pad_retry txp_pad_retry_chk #(.RTY_W(RTY_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .col_i         (col_i),
  .done_i        (done_i),
  .retry_limit_i (retry_limit_i),
  .pad_pattern_i (pad_pattern_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_last_o    (out_last_o),
  .src_ready_o   (src_ready_o),
  .rewind_o      (rewind_o),
  .abort_irq_o   (abort_irq_o),
  .state_q       (state_q)
);

// File: tb/test_txp_pad_retry.sv
module test_txp_pad_retry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pad_pattern_i = 16'h0000;
  logic [15:0] min_len_i = 16'd64;
  logic [15:0] retry_limit_i = 16'd15;
  logic        start_i = 1'b0, col_i = 1'b0, done_i = 1'b0;
  logic        src_valid_i, src_last_i, src_ready_o;
  logic [7:0]  src_data_i;
  logic        out_valid_o, out_last_o, out_ready_i = 1'b1;
  logic [7:0]  out_data_o;
  logic        rewind_o, abort_irq_o;

  always #10 clk_i = ~clk_i;

  // bench-side byte source
  int       body_len = 0, src_idx = 0, cyc = 0;
  bit       src_on = 0, src_gap = 0, stall = 0;
  logic [7:0] seed = 8'h00;
  assign src_valid_i = src_on && (src_idx < body_len) && !src_gap;
  assign src_data_i  = seed + 8'(src_idx * 7);
  assign src_last_i  = (src_idx == body_len - 1);

  txp_pad_retry i_txp_pad_retry (
    .clk_i, .rst_ni, .pad_pattern_i, .min_len_i, .retry_limit_i,
    .start_i, .col_i, .done_i, .src_valid_i, .src_data_i, .src_last_i,
    .src_ready_o, .out_valid_o, .out_data_o, .out_last_o, .out_ready_i,
    .rewind_o, .abort_irq_o
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] got [0:255];
  int got_n = 0, n_last = 0, last_idx = -1, n_rew = 0, n_abort = 0;
  bit saw_last = 0, finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_flow();
    out_ready_i = !(stall && (cyc % 3 == 1));
    src_gap     = stall && (cyc % 4 == 2);
  endtask

  // inputs already set in the low phase; sample, then move to next low phase
  task automatic step();
    bit hs, rw;
    #2;
    if (out_valid_o && out_ready_i && got_n < 256) begin
      got[got_n] = out_data_o;
      if (out_last_o) begin n_last++; last_idx = got_n; saw_last = 1; end
      got_n++;
    end
    hs = src_valid_i && src_ready_o;
    rw = rewind_o;
    if (rw) n_rew++;
    if (abort_irq_o) n_abort++;
    @(negedge clk_i);
    cyc++;
    if (rw) begin src_idx = 0; got_n = 0; n_last = 0; last_idx = -1; saw_last = 0; end
    else if (hs) src_idx++;
  endtask

  function automatic int pad_target(int minl);
    return (minl > 4) ? minl - 4 : 0;
  endfunction

  task automatic begin_frame(int blen, int minl, logic [15:0] pat, int lim);
    min_len_i = 16'(minl); pad_pattern_i = pat; retry_limit_i = 16'(lim);
    body_len = blen; src_idx = 0; got_n = 0; n_last = 0; last_idx = -1;
    saw_last = 0; n_rew = 0; n_abort = 0; src_on = 1;
    seed = 8'(blen * 13 + minl);
    start_i = 1; drive_flow(); step(); start_i = 0;
  endtask

  task automatic check_content(int blen, int minl, logic [15:0] pat, string req);
    int tot, bad;
    tot = (blen > pad_target(minl)) ? blen : pad_target(minl);
    bad = 0;
    for (int i = 0; i < got_n; i++) begin
      logic [7:0] e;
      e = (i < blen) ? (seed + 8'(i * 7)) : pat[7:0];
      if (got[i] !== e) bad++;
    end
    chk(got_n == tot, req, got_n, tot);
    chk(bad == 0, "R2 byte content", bad, 0);
    chk(n_last == 1 && last_idx == tot - 1, "R9 last flag position", last_idx, tot - 1);
  endtask

  task automatic finish_frame(int early_done);
    int guard;
    guard = 0;
    while (!saw_last && guard < 400) begin
      drive_flow();
      done_i = (early_done > 0);
      if (early_done > 0) early_done--;
      step(); guard++;
    end
    done_i = 0; out_ready_i = 1; src_gap = 0;
    done_i = 1; step(); done_i = 0; src_on = 0;
    chk(src_ready_o == 0 && out_valid_o == 0, "R9 idle after done", src_ready_o, 0);
  endtask

  task automatic run_frame(int blen, int minl, logic [15:0] pat, string req);
    begin_frame(blen, minl, pat, 15);
    finish_frame(0);
    check_content(blen, minl, pat, req);
  endtask

  // ncol collisions, 3 cycles apart; optional stray start before collision mid_start
  task automatic frame_cols(int blen, int minl, int lim, int ncol, int mid_start);
    begin_frame(blen, minl, 16'h5A5A, lim);
    for (int c = 0; c < ncol; c++) begin
      if (n_abort != 0) break;
      if (c == mid_start) begin start_i = 1; step(); start_i = 0; end
      repeat (3) begin drive_flow(); step(); end
      col_i = 1; step(); col_i = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    col_i = 1; #2;
    chk(out_valid_o == 0 && src_ready_o == 0 && out_last_o == 0, "R1 reset outputs", out_valid_o, 0);
    chk(rewind_o == 0 && abort_irq_o == 0, "R1 reset irq", abort_irq_o, 0);
    @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    #2;
    chk(rewind_o == 0 && abort_irq_o == 0, "R1 idle collision ignored", rewind_o, 0);
    @(negedge clk_i); col_i = 0;

    // R2/R3/R4/R5 sweep
    for (int s = 0; s < 2; s++) begin
      stall = (s == 1);
      for (int m = 0; m < 4; m++) begin
        int minl;
        minl = (m == 0) ? 4 : (m == 1) ? 2 : (m == 2) ? 10 : 16;
        for (int b = 1; b <= 20; b++) begin
          logic [15:0] pat;
          pat = {8'(b * 3 + 1), 8'(b * 3 + 1)};
          if (minl <= 4)                 run_frame(b, minl, pat, "R5 no pad small min");
          else if (b < pad_target(minl)) run_frame(b, minl, pat, "R3 padded length");
          else                           run_frame(b, minl, pat, "R4 unpadded length");
        end
      end
    end
    stall = 0;

    // R6: retries left, frame restarts and completes
    frame_cols(5, 16, 3, 2, -1);
    finish_frame(0);
    check_content(5, 16, 16'h5A5A, "R6 restarted frame length");
    chk(n_rew == 2 && n_abort == 0, "R6 rewind count", n_rew, 2);

    // R7: exhaustion
    frame_cols(5, 16, 3, 4, -1);
    chk(n_rew == 3 && n_abort == 1, "R7 abort after limit", n_abort, 1);
    chk(src_ready_o == 0 && out_valid_o == 0, "R7 idle after abort", out_valid_o, 0);
    src_on = 0; step();

    // R8: reload on next frame, and zero limit
    frame_cols(8, 16, 3, 4, -1);
    chk(n_rew == 3 && n_abort == 1, "R8 reload per frame", n_rew, 3);
    src_on = 0; step();
    frame_cols(8, 16, 0, 1, -1);
    chk(n_rew == 0 && n_abort == 1, "R8 zero limit aborts", n_abort, 1);
    src_on = 0; step();

    // R10: stray start mid frame does not reload
    frame_cols(8, 16, 3, 6, 2);
    chk(n_rew == 3 && n_abort == 1, "R10 start ignored while active", n_rew, 3);
    src_on = 0; step();

    // R9: early done ignored
    begin_frame(6, 16, 16'hC3C3, 15);
    finish_frame(4);
    check_content(6, 16, 16'hC3C3, "R9 early done ignored");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule